// File: doc/BRIEF.md
# Two-Source Clock Crossbar with Gated Output Banks

This block takes two free-running clocks and steers them onto two output banks, A and B, each of which drives a group of identical clock outputs with a complementary copy beside every one. A 2-bit select picks one of four routings: both banks from the first clock, both from the second, a straight split, and a crossed split.

Each bank has an active-low disable input that may change at any moment, with no relation to either clock. The block resynchronises it to the clock the bank currently carries and switches the gate only while that clock is low. A bank therefore starts and stops on whole high phases and never emits a shortened pulse. A disabled bank parks its true outputs low and its complementary outputs high. An asynchronous active-low reset opens both gates. The select is expected to change only while the outputs are not in use, because a select change itself is not smoothed.

Top module: `clk_xbar_gated`

## Requirements
- R1: With sel = 2'b00, every output of bank A and of bank B equals clk0 while the bank is enabled.
- R2: With sel = 2'b01, every output of both banks equals clk1 while the bank is enabled.
- R3: With sel = 2'b10, bank A outputs equal clk0 and bank B outputs equal clk1 while enabled.
- R4: With sel = 2'b11 (crossed), bank A outputs equal clk1 and bank B outputs equal clk0 while enabled.
- R5: Each complementary output (qa_n, qb_n) is at all times the bitwise inverse of its true output, whether the bank is enabled or disabled.
- R6: With the default of three synchroniser stages, after a bank's disable input rises, the bank produces exactly three more rising edges. Its last falling edge comes more than 2.5 and at most 3.5 routed-clock periods after the change, and the bank then holds its true outputs at 0 and its complementary outputs at all ones.
- R7: With the default of three synchroniser stages, after a bank's disable input falls, the first rising edge on that bank comes more than 3 and at most 4 routed-clock periods after the change.
- R8: Every high pulse on an output starts on a rising edge of the routed source and lasts exactly that source's high phase, including the pulses next to an enable change.
- R9: While rst_n is low, both banks are enabled whatever their disable inputs are, and their outputs follow the routed clock. After rst_n is released with a disable input held high, that bank goes to its disabled level.
- R10: A disable input acts only on its own bank; the other bank keeps toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset; opens both gates |
| clk0 | input | 1 | First source clock |
| clk1 | input | 1 | Second source clock |
| sel | input | 2 | Routing mode select |
| oe_a_n | input | 1 | Bank A disable, active high (0 = toggle) |
| oe_b_n | input | 1 | Bank B disable, active high (0 = toggle) |
| qa | output | FANOUT | Bank A true clock outputs |
| qa_n | output | FANOUT | Bank A complementary outputs |
| qb | output | FANOUT | Bank B true clock outputs |
| qb_n | output | FANOUT | Bank B complementary outputs |

## Verification
A wrong routing term shows up within half a period of the slower clock: an output samples high while its expected source is low. A synchroniser pipeline one stage too short or too long moves the last or first output edge out of its one-period window, and changes the count of rising edges after a disable from three. A gate register clocked on the wrong edge appears at the very first enable change as a pulse narrower than the source high phase. A reset of the wrong polarity shows up at once, because the bank stays quiet while reset is held.

// File: rtl/clk_xbar_gated.sv
module clk_xbar_gated #(
  parameter int FANOUT      = 3,
  parameter int SYNC_STAGES = 3
) (
  input  logic              rst_n,
  input  logic              clk0,
  input  logic              clk1,
  input  logic [1:0]        sel,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  output logic [FANOUT-1:0] qa,
  output logic [FANOUT-1:0] qa_n,
  output logic [FANOUT-1:0] qb,
  output logic [FANOUT-1:0] qb_n
);

  localparam int NBANK = 2;

  logic [NBANK-1:0] rclk;
  logic [NBANK-1:0] off_req;
  logic [NBANK-1:0] bank_off;

  // bank A takes clk1 when sel[0] is set; bank B when the two bits differ
  assign rclk[0] = sel[0] ? clk1 : clk0;
  assign rclk[1] = (sel[0] ^ sel[1]) ? clk1 : clk0;
  assign off_req = {oe_b_n, oe_a_n};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [SYNC_STAGES-1:0] pipe;
    logic                   gate_q;

    always_ff @(posedge rclk[b] or negedge rst_n)
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[SYNC_STAGES-2:0], off_req[b]};

    // updated only while the routed clock is low, so a high phase is never cut
    always_ff @(negedge rclk[b] or negedge rst_n)
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= pipe[SYNC_STAGES-1];

    assign bank_off[b] = gate_q;
  end

  assign qa   = {FANOUT{rclk[0] & ~bank_off[0]}};
  assign qb   = {FANOUT{rclk[1] & ~bank_off[1]}};
  assign qa_n = ~qa;
  assign qb_n = ~qb;

endmodule

// File: rtl/clk_xbar_gated_chk.sv
module clk_xbar_gated_chk #(
  parameter int FANOUT = 3
) (
  input logic              rst_n,
  input logic [1:0]        sel,
  input logic              oe_a_n,
  input logic              oe_b_n,
  input logic [FANOUT-1:0] qa,
  input logic [FANOUT-1:0] qb,
  input logic [1:0]        rclk,
  input logic [1:0]        bank_off
);

  logic [1:0]        dis_n;
  logic [FANOUT-1:0] q [2];

  assign dis_n = {oe_b_n, oe_a_n};
  assign q[0]  = qa;
  assign q[1]  = qb;

  for (genvar b = 0; b < 2; b++) begin : g_chk
    logic [2:0] hi_run;
    logic [2:0] lo_run;
    logic [1:0] sel_q;

    // runs of routed-clock falling edges with a steady disable input and select
    always_ff @(negedge rclk[b] or negedge rst_n)
      if (!rst_n) begin
        hi_run <= '0;
        lo_run <= '0;
        sel_q  <= '0;
      end else if (sel != sel_q) begin
        hi_run <= '0;
        lo_run <= '0;
        sel_q  <= sel;
      end else begin
        hi_run <= dis_n[b]  ? ((hi_run == 3'd7) ? hi_run : hi_run + 3'd1) : 3'd0;
        lo_run <= !dis_n[b] ? ((lo_run == 3'd7) ? lo_run : lo_run + 3'd1) : 3'd0;
      end

    a_r6_gate_closes: assert property (@(negedge rclk[b]) disable iff (!rst_n)
      (hi_run >= 3'd5 && dis_n[b] && sel == sel_q) |-> bank_off[b]);

    a_r7_gate_opens: assert property (@(negedge rclk[b]) disable iff (!rst_n)
      (lo_run >= 3'd5 && !dis_n[b] && sel == sel_q) |-> !bank_off[b]);

    always @(bank_off[b]) begin
      if (rst_n) begin
        a_r8_gate_moves_low: assert (!rclk[b]);
      end
    end

    always @(posedge q[b][0]) begin
      if (rst_n) begin
        a_r8_pulse_opens_whole: assert (rclk[b] && !bank_off[b]);
      end
    end
  end

endmodule

bind clk_xbar_gated clk_xbar_gated_chk #(.FANOUT(FANOUT)) u_chk (
  .rst_n    (rst_n),
  .sel      (sel),
  .oe_a_n   (oe_a_n),
  .oe_b_n   (oe_b_n),
  .qa       (qa),
  .qb       (qb),
  .rclk     (rclk),
  .bank_off (bank_off)
);

// File: tb/test_clk_xbar_gated.sv
`timescale 1ns/1ps
module test_clk_xbar_gated;

  localparam int  FANOUT = 3;
  localparam real T0 = 8.0;
  localparam real T1 = 12.0;
  localparam real EPS = 0.01;

  logic rst_n = 1'b0;
  logic clk0 = 1'b0;
  logic clk1 = 1'b0;
  logic [1:0] sel = 2'b00;
  logic oe_a_n = 1'b0;
  logic oe_b_n = 1'b0;
  logic [FANOUT-1:0] qa, qa_n, qb, qb_n;

  int checks = 0;
  int errors = 0;

  always #4 clk0 = ~clk0;
  always #6 clk1 = ~clk1;

  clk_xbar_gated #(.FANOUT(FANOUT), .SYNC_STAGES(3)) i_clk_xbar_gated (
    .rst_n(rst_n), .clk0(clk0), .clk1(clk1), .sel(sel),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .qa(qa), .qa_n(qa_n), .qb(qb), .qb_n(qb_n)
  );

  // routing table from R1..R4: period of the clock each bank carries
  function automatic real src_period(logic [1:0] s, int b);
    case (s)
      2'b00: return T0;
      2'b01: return T1;
      2'b10: return (b == 0) ? T0 : T1;
      default: return (b == 0) ? T1 : T0;
    endcase
  endfunction

  function automatic logic src_level(logic [1:0] s, int b);
    return (src_period(s, b) == T0) ? clk0 : clk1;
  endfunction

  function automatic logic [FANOUT-1:0] get_q(int b);
    return (b == 0) ? qa : qb;
  endfunction

  function automatic logic [FANOUT-1:0] get_qn(int b);
    return (b == 0) ? qa_n : qb_n;
  endfunction

  task automatic report(bit ok, string req, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic set_dis(int b, logic v);
    if (b == 0) oe_a_n = v;
    else        oe_b_n = v;
  endtask

  // edge monitors
  real rise_t [2];
  real fall_t [2];
  real first_rise [2];
  int  rises [2];
  bit  want_first [2];
  bit  rise_ok [2];
  bit  pulse_on = 1'b0;

  task automatic on_rise(int b);
    rises[b]++;
    rise_t[b] = $realtime;
    rise_ok[b] = pulse_on;
    if (want_first[b]) begin
      first_rise[b] = $realtime;
      want_first[b] = 1'b0;
    end
  endtask

  task automatic on_fall(int b);
    real w, hp;
    fall_t[b] = $realtime;
    if (pulse_on && rise_ok[b]) begin
      w  = fall_t[b] - rise_t[b];
      hp = src_period(sel, b) / 2.0;
      report((w > hp - EPS) && (w < hp + EPS), "R8",
             $sformatf("bank %0d pulse width actual %0.3f expected %0.3f", b, w, hp));
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      rise_t[i] = 0.0; fall_t[i] = 0.0; first_rise[i] = 0.0;
      rises[i] = 0; want_first[i] = 1'b0; rise_ok[i] = 1'b0;
    end
  end

  always @(posedge qa[0]) on_rise(0);
  always @(negedge qa[0]) on_fall(0);
  always @(posedge qb[0]) on_rise(1);
  always @(negedge qb[0]) on_fall(1);

  // samples land on odd nanoseconds, never on a clock edge
  task automatic sample_route(string req, int n);
    @(posedge clk0);
    #1;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 2; b++) begin
        logic [FANOUT-1:0] exp_q;
        exp_q = {FANOUT{src_level(sel, b)}};
        report(get_q(b) === exp_q, req,
               $sformatf("sel %b bank %0d q actual %b expected %b", sel, b, get_q(b), exp_q));
        report(get_qn(b) === ~get_q(b), "R5",
               $sformatf("bank %0d complement actual %b expected %b", b, get_qn(b), ~get_q(b)));
      end
      #2;
    end
  endtask

  task automatic change_sel(logic [1:0] s);
    if (sel != s) begin
      pulse_on = 1'b0;
      sel = s;
      #51;
      pulse_on = 1'b1;
    end
  endtask

  function automatic real rand_phase();
    return 2.0 * $urandom_range(0, 5) + 1.0 + 0.25 * $urandom_range(0, 3);
  endfunction

  task automatic lat_run(int b, logic [1:0] s);
    real tp, tc, d;
    int  r0, ro, other;
    change_sel(s);
    other = 1 - b;
    tp = src_period(s, b);

    @(posedge clk0);
    #(rand_phase());
    tc = $realtime;
    r0 = rises[b];
    ro = rises[other];
    set_dis(b, 1'b1);
    #(8.0 * tp);
    report(rises[b] - r0 == 3, "R6",
           $sformatf("bank %0d rises after disable actual %0d expected 3", b, rises[b] - r0));
    d = fall_t[b] - tc;
    report((d > 2.5 * tp + EPS) && (d <= 3.5 * tp + EPS), "R6",
           $sformatf("bank %0d stop delay actual %0.3f expected (%0.1f,%0.1f]", b, d, 2.5 * tp, 3.5 * tp));
    report(get_q(b) === '0 && get_qn(b) === '1, "R6",
           $sformatf("bank %0d parked level actual %b/%b expected %b/%b", b, get_q(b), get_qn(b),
                     {FANOUT{1'b0}}, {FANOUT{1'b1}}));
    report(rises[other] - ro >= 4, "R10",
           $sformatf("bank %0d rises while other disabled actual %0d expected >=4", other, rises[other] - ro));

    @(posedge clk0);
    #(rand_phase());
    tc = $realtime;
    want_first[b] = 1'b1;
    set_dis(b, 1'b0);
    #(8.0 * tp);
    d = first_rise[b] - tc;
    report(!want_first[b] && (d > 3.0 * tp + EPS) && (d <= 4.0 * tp + EPS), "R7",
           $sformatf("bank %0d restart delay actual %0.3f expected (%0.1f,%0.1f]", b, d, 3.0 * tp, 4.0 * tp));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));

    // R9: reset holds both banks open even with bank A disabled
    oe_a_n = 1'b1;
    #3;
    @(posedge clk0);
    #1;
    for (int i = 0; i < 8; i++) begin
      report(qa === {FANOUT{clk0}} && qb === {FANOUT{clk0}}, "R9",
             $sformatf("in reset qa %b qb %b expected both %b", qa, qb, {FANOUT{clk0}}));
      #2;
    end
    #0.5;
    rst_n = 1'b1;
    #64;
    report(qa === '0 && qa_n === '1, "R9",
           $sformatf("after reset bank A actual %b/%b expected parked", qa, qa_n));
    report(qb === {FANOUT{clk0}}, "R9",
           $sformatf("after reset bank B actual %b expected %b", qb, {FANOUT{clk0}}));
    oe_a_n = 1'b0;
    #101;
    pulse_on = 1'b1;

    sample_route("R1", 24);
    change_sel(2'b01);
    sample_route("R2", 24);
    change_sel(2'b10);
    sample_route("R3", 24);
    change_sel(2'b11);
    sample_route("R4", 24);

    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 2; b++) begin
        lat_run(b, 2'(s));
      end
    end

    for (int i = 0; i < 20; i++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      lat_run(int'($urandom_range(0, 1)), s);
      sample_route((s == 2'b00) ? "R1" : (s == 2'b01) ? "R2" : (s == 2'b10) ? "R3" : "R4", 6);
    end

    finish_run();
  end

endmodule